// File: doc/BRIEF.md
# Controller Command and Interrupt Status Block

This block sits between the host bus and the two engines of a descriptor-driven Ethernet controller: the command unit and the receive unit. Four host-visible registers are decoded at small offsets. They are an interrupt control byte, a command byte, an event status byte and a 32-bit general pointer. The pointer is also driven straight to both units, which use it as the operand of their commands.

A write to the command byte issues both unit commands at once. The upper nibble goes to the command unit and the low three bits go to the receive unit. Each unit sees a one-cycle strobe with its command, but only when its field is non-zero. The units report events through single-cycle pulses that latch status bits. The host reads these bits back and clears them by writing ones.

A single level interrupt is derived from the status and the interrupt control byte under a fixed priority. A global mask is checked first, then a software trigger, then the per-event masks of the upper status nibble.

Top module: `nic_sysctl`

## Requirements
- R1: After reset the interrupt control byte, the status byte and the general pointer are zero. The interrupt output and both command strobes are low.
- R2: A write to offset 0x04 loads all 32 bits of the general pointer. The value reads back at offset 0x04 and appears on `gen_ptr` in the cycle after the write.
- R3: A write to offset 0x01 raises `cu_cmd_vld` for exactly one cycle after the write, with `cu_cmd` equal to data bits 7:4. The same write raises `ru_cmd_vld` with `ru_cmd` equal to data bits 2:0. Data bit 3 has no effect.
- R4: A command field of zero produces no strobe for that unit, and the other unit's strobe is unaffected.
- R5: An `unit_evt` pulse on bit i sets status bit i from the next cycle. The implemented bits are 7, 6, 5, 4, 3, 2 and 0. Bit 1 is reserved and always reads 0. A read of offset 0x02 returns the status byte in bits 15:8, with zero elsewhere.
- R6: A write to offset 0x02 clears each status bit whose position holds a 1 in data bits 15:8. All other status bits keep their value, and data bits 7:0 are ignored.
- R7: When an event pulse and an acknowledge of the same bit fall in the same cycle, the bit ends up set.
- R8: While interrupt control bit 0 is 1, the interrupt output is low whatever the status.
- R9: While interrupt control bit 0 is 0 and bit 1 is 1, the interrupt output is high.
- R10: Otherwise the interrupt is high exactly when some status bit in 7:4 is 1 and the same bit of the interrupt control byte is 0. Status bits 3:0 never raise it. The output follows the registered state with no extra delay, after events, acknowledges and control writes alike.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Host write strobe |
| bus_addr | input | ADDR_W | Host byte offset |
| bus_wdata | input | DATA_W | Host write data |
| bus_rdata | output | DATA_W | Host read data (combinational from `bus_addr`) |
| unit_evt | input | 8 | Event set pulses from the units, one per status bit |
| cu_cmd_vld | output | 1 | Command-unit command strobe |
| cu_cmd | output | 4 | Command-unit command code |
| ru_cmd_vld | output | 1 | Receive-unit command strobe |
| ru_cmd | output | 3 | Receive-unit command code |
| gen_ptr | output | DATA_W | General pointer driven to the units |
| irq | output | 1 | Level interrupt request |

## Verification
The interrupt output depends jointly on all eight control bits and on the upper status nibble. A single directed case cannot expose a mask bit wired to the wrong event. The stimulus therefore loads each of the sixteen upper-nibble status patterns through event pulses, together with fixed low status bits. Under each pattern it then sweeps all 256 interrupt control values and compares the output to an arithmetic model. The set-versus-clear collision is reached by driving an event pulse and an acknowledge write in the same cycle.

// File: rtl/nic_sysctl_pkg.sv
package nic_sysctl_pkg;
   localparam int STAT_W   = 8;
   localparam int OFF_ICB  = 0;
   localparam int OFF_CMD  = 1;
   localparam int OFF_STAT = 2;
   localparam int OFF_PTR  = 4;
   localparam logic [STAT_W-1:0] STAT_IMPL = 8'hFD;
   localparam int CU_LSB = 4;
   localparam int CU_W   = 4;
   localparam int RU_LSB = 0;
   localparam int RU_W   = 3;
   localparam int ACK_LSB = 8;
   localparam int BIT_MASK_ALL = 0;
   localparam int BIT_SWI      = 1;
   localparam int EVT_LSB      = 4;

   typedef struct packed {
      logic icb;
      logic cmd;
      logic ack;
      logic ptr;
   } wr_sel_t;
endpackage

// File: rtl/nic_sysctl_decode.sv
module nic_sysctl_decode
   import nic_sysctl_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [STAT_W-1:0] stat_q,
   input  logic [DATA_W-1:0] ptr_q,
   output wr_sel_t           wsel,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [ADDR_W-1:0] A_ICB  = ADDR_W'(OFF_ICB);
   localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
   localparam logic [ADDR_W-1:0] A_PTR  = ADDR_W'(OFF_PTR);

   always_comb begin
      wsel.icb = bus_wr && (bus_addr == A_ICB);
      wsel.cmd = bus_wr && (bus_addr == A_CMD);
      wsel.ack = bus_wr && (bus_addr == A_STAT);
      wsel.ptr = bus_wr && (bus_addr == A_PTR);
   end

   always_comb begin
      rdata = '0;
      if (bus_addr == A_STAT)
         rdata[ACK_LSB +: STAT_W] = stat_q;
      else if (bus_addr == A_PTR)
         rdata = ptr_q;
   end
endmodule

// File: rtl/nic_sysctl_cmd.sv
module nic_sysctl_cmd
   import nic_sysctl_pkg::*;
(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_we,
   input  logic [7:0]      cmd_byte,
   output logic            cu_vld,
   output logic [CU_W-1:0] cu_code,
   output logic            ru_vld,
   output logic [RU_W-1:0] ru_code
);
   logic [CU_W-1:0] cu_f;
   logic [RU_W-1:0] ru_f;

   assign cu_f = cmd_byte[CU_LSB +: CU_W];
   assign ru_f = cmd_byte[RU_LSB +: RU_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cu_vld  <= 1'b0;
         ru_vld  <= 1'b0;
         cu_code <= '0;
         ru_code <= '0;
      end else begin
         cu_vld <= cmd_we && (cu_f != '0);
         ru_vld <= cmd_we && (ru_f != '0);
         if (cmd_we) begin
            cu_code <= cu_f;
            ru_code <= ru_f;
         end
      end
   end
endmodule

// File: rtl/nic_sysctl_stat.sv
module nic_sysctl_stat
   import nic_sysctl_pkg::*;
#(
   parameter logic [STAT_W-1:0] IMPL = STAT_IMPL
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] set_i,
   input  logic [STAT_W-1:0] clr_i,
   output logic [STAT_W-1:0] stat_q
);
   for (genvar i = 0; i < STAT_W; i++) begin : g_bit
      if (IMPL[i]) begin : g_live
         always_ff @(posedge clk) begin
            if (!rst_n)
               stat_q[i] <= 1'b0;
            else
               stat_q[i] <= set_i[i] | (stat_q[i] & ~clr_i[i]);
         end
      end else begin : g_rsvd
         assign stat_q[i] = 1'b0;
      end
   end
endmodule

// File: rtl/nic_sysctl_irq.sv
module nic_sysctl_irq
   import nic_sysctl_pkg::*;
(
   input  logic [7:0]        icb,
   input  logic [STAT_W-1:0] stat,
   output logic              irq
);
   localparam int EVT_W = STAT_W - EVT_LSB;
   logic [EVT_W-1:0] live;

   assign live = stat[STAT_W-1:EVT_LSB] & ~icb[STAT_W-1:EVT_LSB];

   always_comb begin
      if (icb[BIT_MASK_ALL])
         irq = 1'b0;
      else if (icb[BIT_SWI])
         irq = 1'b1;
      else
         irq = |live;
   end
endmodule

// File: rtl/nic_sysctl.sv
module nic_sysctl
   import nic_sysctl_pkg::*;
#(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [7:0]        unit_evt,
   output logic              cu_cmd_vld,
   output logic [3:0]        cu_cmd,
   output logic              ru_cmd_vld,
   output logic [2:0]        ru_cmd,
   output logic [DATA_W-1:0] gen_ptr,
   output logic              irq
);
   if (DATA_W < ACK_LSB + STAT_W) begin : g_chk_dw
      $error("DATA_W must hold the status field");
   end
   if (ADDR_W < 3) begin : g_chk_aw
      $error("ADDR_W must reach the pointer offset");
   end

   wr_sel_t           wsel;
   logic [7:0]        icb_q;
   logic [STAT_W-1:0] stat_q;
   logic [DATA_W-1:0] ptr_q;

   nic_sysctl_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .stat_q   (stat_q),
      .ptr_q    (ptr_q),
      .wsel     (wsel),
      .rdata    (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         icb_q <= '0;
         ptr_q <= '0;
      end else begin
         if (wsel.icb) icb_q <= bus_wdata[7:0];
         if (wsel.ptr) ptr_q <= bus_wdata;
      end
   end

   nic_sysctl_cmd u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd_we   (wsel.cmd),
      .cmd_byte (bus_wdata[7:0]),
      .cu_vld   (cu_cmd_vld),
      .cu_code  (cu_cmd),
      .ru_vld   (ru_cmd_vld),
      .ru_code  (ru_cmd)
   );

   logic [STAT_W-1:0] clr;
   assign clr = wsel.ack ? bus_wdata[ACK_LSB +: STAT_W] : '0;

   nic_sysctl_stat #(.IMPL(STAT_IMPL)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (unit_evt),
      .clr_i  (clr),
      .stat_q (stat_q)
   );

   nic_sysctl_irq u_irq (
      .icb  (icb_q),
      .stat (stat_q),
      .irq  (irq)
   );

   assign gen_ptr = ptr_q;
endmodule

// File: rtl/nic_sysctl_chk.sv
module nic_sysctl_chk #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [7:0]        unit_evt,
   input logic              cu_cmd_vld,
   input logic [3:0]        cu_cmd,
   input logic              ru_cmd_vld,
   input logic [7:0]        icb_q,
   input logic [7:0]        stat_q,
   input logic              irq
);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(1);
   localparam logic [7:0] IMPL = 8'hFD;

   AST_CU_STROBE_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      cu_cmd_vld |-> ($past(bus_wr) && $past(bus_addr) == A_CMD
                      && $past(bus_wdata[7:4]) == cu_cmd)); // R3
   AST_RU_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CMD && bus_wdata[2:0] == 3'd0) |=> !ru_cmd_vld); // R4
   AST_CU_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CMD && bus_wdata[7:4] == 4'd0) |=> !cu_cmd_vld); // R4
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_q[1]); // R5
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(unit_evt & IMPL)) |=>
         ((stat_q & $past(unit_evt & IMPL)) == $past(unit_evt & IMPL))); // R7
   AST_MASK_ALL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      icb_q[0] |-> !irq); // R8
   AST_SWI_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (!icb_q[0] && icb_q[1]) |-> irq); // R9
   AST_LOW_NIBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (icb_q[1:0] == 2'b00 && (stat_q[7:4] & ~icb_q[7:4]) == 4'd0) |-> !irq); // R10
endmodule

bind nic_sysctl nic_sysctl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .unit_evt   (unit_evt),
   .cu_cmd_vld (cu_cmd_vld),
   .cu_cmd     (cu_cmd),
   .ru_cmd_vld (ru_cmd_vld),
   .icb_q      (icb_q),
   .stat_q     (stat_q),
   .irq        (irq)
);

// File: tb/nic_sysctl_tb.sv
module nic_sysctl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 5;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_wr = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [7:0]    unit_evt = '0;
   logic          cu_cmd_vld;
   logic [3:0]    cu_cmd;
   logic          ru_cmd_vld;
   logic [2:0]    ru_cmd;
   logic [DW-1:0] gen_ptr;
   logic          irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nic_sysctl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .unit_evt(unit_evt),
      .cu_cmd_vld(cu_cmd_vld), .cu_cmd(cu_cmd), .ru_cmd_vld(ru_cmd_vld),
      .ru_cmd(ru_cmd), .gen_ptr(gen_ptr), .irq(irq)
   );

   task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
   endtask

   task automatic pulse(logic [7:0] e);
      @(negedge clk);
      unit_evt = e;
      @(negedge clk);
      unit_evt = '0;
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
      bus_addr = '0;
   endtask

   function automatic logic model_irq(logic [7:0] icb, logic [7:0] st);
      if (icb[0]) return 1'b0;
      if (icb[1]) return 1'b1;
      return |(st[7:4] & ~icb[7:4]);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : main
      logic [DW-1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 cu strobe", {31'b0, cu_cmd_vld}, 0);
      chk("R1 ru strobe", {31'b0, ru_cmd_vld}, 0);
      chk("R1 gen_ptr", gen_ptr, 0);
      rd(2, r); chk("R1 status", r, 0);

      // R2 general pointer
      wr(4, 32'hA5C3_0F96);
      chk("R2 gen_ptr", gen_ptr, 32'hA5C3_0F96);
      rd(4, r); chk("R2 readback", r, 32'hA5C3_0F96);
      wr(4, 32'hFFFF_FFFF);
      rd(4, r); chk("R2 all ones", r, 32'hFFFF_FFFF);

      // R3 R4 sweep of every command byte
      for (int c = 0; c < 256; c++) begin
         wr(1, DW'(c));
         chk("R3 R4 cu vld", {31'b0, cu_cmd_vld}, DW'(c[7:4] != 0));
         chk("R3 R4 ru vld", {31'b0, ru_cmd_vld}, DW'(c[2:0] != 0));
         if (c[7:4] != 0) chk("R3 cu code", DW'(cu_cmd), DW'(c[7:4]));
         if (c[2:0] != 0) chk("R3 ru code", DW'(ru_cmd), DW'(c[2:0]));
         @(negedge clk);
         chk("R3 cu single cycle", {31'b0, cu_cmd_vld}, 0);
         chk("R3 ru single cycle", {31'b0, ru_cmd_vld}, 0);
      end

      // R5 each event bit, reserved bit 1 stays 0
      for (int b = 0; b < 8; b++) begin
         pulse(8'(1 << b));
         rd(2, r);
         chk("R5 status set", r, (b == 1) ? 0 : DW'(32'h1 << (b + 8)));
         wr(2, 32'hFF00);
         rd(2, r); chk("R6 cleared", r, 0);
      end

      // R6 partial clear, low data bits ignored
      pulse(8'hFD);
      wr(2, 32'h0000_50FF);
      rd(2, r); chk("R6 partial clear", r, 32'h0000_AD00);
      wr(2, 32'hFF00);

      // R7 set wins over same-cycle clear
      pulse(8'h20);
      @(negedge clk);
      unit_evt = 8'h81; bus_wr = 1'b1; bus_addr = 2; bus_wdata = 32'h0000_A100;
      @(negedge clk);
      unit_evt = '0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
      rd(2, r); chk("R7 set wins", r, 32'h0000_8100);
      wr(2, 32'hFF00);

      // R8 R9 R10 sweep: status upper nibble x all control bytes
      for (int s = 0; s < 16; s++) begin
         pulse({4'(s), 4'b1101});
         for (int c = 0; c < 256; c++) begin
            wr(0, DW'(c));
            chk(c[0] ? "R8 irq" : (c[1] ? "R9 irq" : "R10 irq"),
                {31'b0, irq}, DW'(model_irq(8'(c), {4'(s), 4'b1101})));
         end
         wr(0, 0);
         wr(2, 32'h0000_FF00);
         chk("R10 irq after ack", {31'b0, irq}, 0);
      end

      // R10 irq rises straight after event with control zero
      pulse(8'h40);
      chk("R10 irq after event", {31'b0, irq}, 1);
      wr(2, 32'h0000_4000);
      chk("R10 irq after ack", {31'b0, irq}, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule